// File: doc/BRIEF.md
# Analog Control Slave Register File

This block is the slave end of a narrow register bus that configures analog circuitry. It holds a bank of 8-bit control registers, and their contents leave the block on a flat output vector that feeds the analog circuits. A master sends one transaction at a time. A write transaction carries one of four operations: replace, bitwise set, bitwise clear, or a masked update confined to a single 4-bit half of the register. Because these operations are applied inside the slave, the master never needs a read-modify-write sequence. A read transaction returns one nibble of the addressed register.

Requests enter on a valid/ready channel. `req_ready` is high whenever reset is low, so every request presented outside reset is accepted on the clock edge where `req_valid` is sampled high. The response channel has no back-pressure. `rsp_valid` pulses for exactly one cycle, one cycle after the request, and the master must take `rsp_rdata` in that cycle. A register update takes effect on the same edge that raises `rsp_valid`. The address space has 16 slots. Only the lowest `NUM_REGS` slots hold registers. The other slots acknowledge requests, ignore writes and read as zero.

Top module: `ana_slave_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to 0x00 and holds `rsp_valid` low.
- R2: A write request with operation code 00 on an implemented address replaces the register with `req_wdata`.
- R3: Operation code 01 sets the register bits that are 1 in `req_wdata`, giving reg | wdata, and leaves the other bits unchanged.
- R4: Operation code 10 clears the register bits that are 1 in `req_wdata`, giving reg & ~wdata, and leaves the other bits unchanged.
- R5: Operation code 11 is a masked write to one nibble. `req_nib` = 0 selects bits 3:0 and `req_nib` = 1 selects bits 7:4. The selected nibble becomes (nib & ~req_mask) | (req_wdata[3:0] & req_mask), and the other nibble is unchanged.
- R6: A read request (`req_write` = 0) returns bits 3:0 of the register when `req_nib` = 0 and bits 7:4 when `req_nib` = 1. The value returned is the register as it stood when the request was sampled. A read leaves every register unchanged.
- R7: Every accepted request produces `rsp_valid` high in exactly the following cycle, and only then. `rsp_rdata` is 0 in the response to a write.
- R8: A request whose address is at or above `NUM_REGS` is acknowledged. If it is a write, it changes no register. If it is a read, it returns 0.
- R9: Requests may arrive in every cycle. A read issued in the cycle right after a write to the same register returns the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (high outside reset) |
| req_write | input | 1 | 1 = write operation, 0 = read |
| req_op | input | 2 | Write operation: 00 replace, 01 set, 10 clear, 11 masked |
| req_addr | input | 4 | Register address |
| req_wdata | input | 8 | Write payload (masked writes use bits 3:0) |
| req_mask | input | 4 | Bit mask for masked writes |
| req_nib | input | 1 | Nibble select for masked writes and reads |
| rsp_valid | output | 1 | Acknowledge, one cycle after the request |
| rsp_rdata | output | 4 | Read nibble |
| ana_ctrl | output | NUM_REGS*8 | All register contents, register i at bits 8i+7:8i |

## Verification
Two things can land on the same clock edge: the register update made by one transaction, and the acknowledge of that transaction while the next request is sampled. The bench provokes this with streams of requests in every cycle, with no idle gaps, so a read often follows a write to the same address. The bench checks each read nibble against a model that has already applied every earlier operation. It also compares the whole control vector with the model after every transaction, so an update that lands late, early or on the wrong register shows up at once.

// File: rtl/ana_slv_pkg.sv
package ana_slv_pkg;
  typedef enum logic [1:0] {
    OP_WR  = 2'b00,
    OP_SET = 2'b01,
    OP_CLR = 2'b10,
    OP_MSK = 2'b11
  } ana_op_e;
endpackage

// File: rtl/ana_op_unit.sv
module ana_op_unit #(
  parameter int DW = 8,
  parameter int NW = 4,
  localparam int NSELW = $clog2(DW / NW)
) (
  input  logic [1:0]       op,
  input  logic [DW-1:0]    cur,
  input  logic [DW-1:0]    wdata,
  input  logic [NW-1:0]    mask,
  input  logic [NSELW-1:0] nib,
  output logic [DW-1:0]    nxt
);
  import ana_slv_pkg::*;
  logic [NW-1:0] old_nib, new_nib;

  always_comb begin
    old_nib = cur[int'(nib)*NW +: NW];
    new_nib = (old_nib & ~mask) | (wdata[NW-1:0] & mask);
    nxt = cur;
    case (ana_op_e'(op))
      OP_WR:   nxt = wdata;
      OP_SET:  nxt = cur | wdata;
      OP_CLR:  nxt = cur & ~wdata;
      default: nxt[int'(nib)*NW +: NW] = new_nib;
    endcase
  end
endmodule

// File: rtl/ana_reg_bank.sv
module ana_reg_bank #(
  parameter int NUM_REGS = 12,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wval,
  output logic [DW-1:0]          rd_word,
  output logic [NUM_REGS*DW-1:0] q_flat
);
  logic [DW-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[i] <= '0;
      else if (we && addr == AW'(i)) regs[i] <= wval;
    end
    assign q_flat[i*DW +: DW] = regs[i];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == AW'(i)) rd_word = regs[i];
  end
endmodule

// File: rtl/ana_nib_mux.sv
module ana_nib_mux #(
  parameter int DW = 8,
  parameter int NW = 4,
  localparam int NSELW = $clog2(DW / NW)
) (
  input  logic [DW-1:0]    word,
  input  logic [NSELW-1:0] sel,
  output logic [NW-1:0]    nib
);
  assign nib = word[int'(sel)*NW +: NW];
endmodule

// File: rtl/ana_slave_regfile.sv
module ana_slave_regfile #(
  parameter int NUM_REGS = 12,
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int NW = 4,
  localparam int NSELW = $clog2(DW / NW)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [1:0]             req_op,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  input  logic [NW-1:0]          req_mask,
  input  logic [NSELW-1:0]       req_nib,
  output logic                   rsp_valid,
  output logic [NW-1:0]          rsp_rdata,
  output logic [NUM_REGS*DW-1:0] ana_ctrl
);
  logic          addr_hit, take, we;
  logic [DW-1:0] cur_word, nxt_word;
  logic [NW-1:0] rd_nib;

  assign req_ready = ~rst;
  assign take      = req_valid & req_ready;
  assign addr_hit  = {1'b0, req_addr} < (AW+1)'(NUM_REGS);
  assign we        = take & req_write & addr_hit;

  ana_reg_bank #(.NUM_REGS(NUM_REGS), .AW(AW), .DW(DW)) bank_i (
    .clk(clk), .rst(rst), .we(we), .addr(req_addr), .wval(nxt_word),
    .rd_word(cur_word), .q_flat(ana_ctrl)
  );

  ana_op_unit #(.DW(DW), .NW(NW)) op_i (
    .op(req_op), .cur(cur_word), .wdata(req_wdata), .mask(req_mask),
    .nib(req_nib), .nxt(nxt_word)
  );

  ana_nib_mux #(.DW(DW), .NW(NW)) mux_i (
    .word(cur_word), .sel(req_nib), .nib(rd_nib)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= take;
      rsp_rdata <= (take && !req_write) ? rd_nib : '0;
    end
  end
endmodule

// File: rtl/ana_slave_regfile_chk.sv
module ana_slave_regfile_chk #(
  parameter int NUM_REGS = 12,
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int NW = 4,
  localparam int NSELW = $clog2(DW / NW)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [1:0]             req_op,
  input logic [AW-1:0]          req_addr,
  input logic [DW-1:0]          req_wdata,
  input logic [NSELW-1:0]       req_nib,
  input logic                   rsp_valid,
  input logic [NW-1:0]          rsp_rdata,
  input logic [NUM_REGS*DW-1:0] ana_ctrl
);
  logic          hit, p_set, p_clr, p_msk;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] cur_w, p_word, p_wd, after_w;
  logic [NSELW-1:0] p_nib;

  assign hit = {1'b0, req_addr} < (AW+1)'(NUM_REGS);
  assign cur_w = hit ? ana_ctrl[int'(req_addr)*DW +: DW] : '0;
  assign after_w = ({1'b0, p_addr} < (AW+1)'(NUM_REGS)) ? ana_ctrl[int'(p_addr)*DW +: DW] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_set <= 1'b0; p_clr <= 1'b0; p_msk <= 1'b0;
      p_addr <= '0; p_word <= '0; p_wd <= '0; p_nib <= '0;
    end else begin
      p_set  <= req_valid && req_write && hit && req_op == 2'b01;
      p_clr  <= req_valid && req_write && hit && req_op == 2'b10;
      p_msk  <= req_valid && req_write && hit && req_op == 2'b11;
      p_addr <= req_addr; p_word <= cur_w; p_wd <= req_wdata; p_nib <= req_nib;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> (!rsp_valid && ana_ctrl == '0));
  // R7
  ack_one_cycle_chk: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid);
  // R7
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid);
  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (rst) p_set |-> after_w == (p_word | p_wd));
  // R4
  clear_bits_chk: assert property (@(posedge clk) disable iff (rst) p_clr |-> after_w == (p_word & ~p_wd));
  // R5
  mask_other_nib_chk: assert property (@(posedge clk) disable iff (rst)
    p_msk |-> after_w[int'(~p_nib)*NW +: NW] == p_word[int'(~p_nib)*NW +: NW]);
  // R8
  unimpl_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !hit) |=> rsp_rdata == '0);
  // R8
  unimpl_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !hit) |=> $stable(ana_ctrl));
endmodule

bind ana_slave_regfile ana_slave_regfile_chk #(.NUM_REGS(NUM_REGS), .AW(AW), .DW(DW), .NW(NW)) chk_i (.*);

// File: tb/ana_slave_regfile_tb_top.sv
`timescale 1ns/100ps
module ana_slave_regfile_tb_top;
  localparam int NUM_REGS = 12;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_nib = 1'b0;
  logic [1:0] req_op = '0;
  logic [3:0] req_addr = '0, req_mask = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [3:0] rsp_rdata;
  logic [NUM_REGS*8-1:0] ana_ctrl;

  int checks = 0, errors = 0;
  logic [7:0] mdl [16];

  always #2.5 clk = ~clk;

  ana_slave_regfile #(.NUM_REGS(NUM_REGS), .AW(AW)) dut_i (.*);

  function automatic logic [7:0] f_apply(logic [1:0] op, logic [7:0] old, logic [7:0] d,
                                         logic [3:0] m, logic nib);
    logic [7:0] r;
    r = old;
    case (op)
      2'b00: r = d;
      2'b01: r = old | d;
      2'b10: r = old & ~d;
      default: r[nib*4 +: 4] = (old[nib*4 +: 4] & ~m) | (d[3:0] & m);
    endcase
    return r;
  endfunction

  function automatic logic [NUM_REGS*8-1:0] f_vec();
    logic [NUM_REGS*8-1:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic txn(string req, logic w, logic [1:0] op, logic [3:0] a, logic [7:0] d,
                     logic [3:0] m, logic n);
    logic [3:0] exp_rd;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_op = op; req_addr = a;
    req_wdata = d; req_mask = m; req_nib = n;
    exp_rd = (!w && a < NUM_REGS) ? mdl[a][n*4 +: 4] : 4'h0;
    if (w && a < NUM_REGS) mdl[a] = f_apply(op, mdl[a], d, m, n);
    @(posedge clk); #1;
    chk({req, " ack"}, 128'(rsp_valid), 128'(1'b1));
    chk({req, " rdata"}, 128'(rsp_rdata), 128'(exp_rd));
    chk({req, " regs"}, 128'(ana_ctrl), 128'(f_vec()));
  endtask

  task automatic idle();
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R7 idle no ack", 128'(rsp_valid), 128'(1'b0));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rsp_valid", 128'(rsp_valid), 128'(1'b0));
    chk("R1 reset regs", 128'(ana_ctrl), 128'(0));
    @(negedge clk); rst = 1'b0;
    // directed corners
    txn("R2 write", 1, 2'b00, 4'd3, 8'hA5, 4'h0, 0);
    txn("R3 set", 1, 2'b01, 4'd3, 8'h0F, 4'h0, 0);
    txn("R4 clear", 1, 2'b10, 4'd3, 8'hA0, 4'h0, 0);
    txn("R5 masked hi", 1, 2'b11, 4'd3, 8'h06, 4'h5, 1);
    txn("R6 R9 read lo", 0, 2'b00, 4'd3, 8'h00, 4'h0, 0);
    txn("R6 read hi", 0, 2'b00, 4'd3, 8'h00, 4'h0, 1);
    txn("R5 masked lo", 1, 2'b11, 4'd3, 8'hF9, 4'hA, 0);
    txn("R9 read after mask", 0, 2'b00, 4'd3, 8'h00, 4'h0, 0);
    idle();
    txn("R8 unimpl write", 1, 2'b00, 4'd14, 8'hFF, 4'h0, 0);
    txn("R8 unimpl read", 0, 2'b00, 4'd14, 8'h00, 4'h0, 1);
    txn("R2 top reg", 1, 2'b00, 4'(NUM_REGS-1), 8'h3C, 4'h0, 0);
    txn("R7 write rdata", 1, 2'b01, 4'(NUM_REGS-1), 8'h81, 4'h0, 1);
    // random back-to-back stream
    for (int k = 0; k < 800; k++) begin
      logic [1:0] op = 2'($urandom);
      logic w = ($urandom % 3) != 0;
      logic [3:0] a = 4'($urandom);
      if ($urandom % 10 == 0) idle();
      else txn(w ? (op == 2'b00 ? "R2 rnd" : op == 2'b01 ? "R3 rnd" :
                    op == 2'b10 ? "R4 rnd" : "R5 rnd") : "R6 R9 rnd read",
               w, op, a, 8'($urandom), 4'($urandom), 1'($urandom));
    end
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule